// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Signature Words

The aggregator gathers up to sixteen external interrupt sources into a single active-low, level-sensitive request line for a host processor. Each source passes through a two-flop synchronizer. A rising edge on the synchronized source sets a sticky status bit. Software decides which bits may raise the request through a mask register, and retires bits through a separate clear register. A bit written 1 in the clear register forces the matching status bit to zero, and keeps forcing it until software writes a 0 back to that bit.

Before using the block, software reads three fixed signature words and a code-revision word to confirm the block is present. All access goes through a synchronous 16-bit register port. A read is requested with `rd_en` and its data appears on `rd_data` one clock later. A write takes effect on the clock edge where `wr_en` is high.

The request line is driven by a two-state machine. In state IRQ_QUIET the line is high. The transition QUIET-to-RAISED is taken when any pending bit (status AND NOT mask) exists, and state IRQ_RAISED drives the line low. The transition RAISED-to-QUIET is taken when no pending bit remains. Because the state is registered, the line follows the pending set one clock later.

Top module: `irqagg_top`

## Requirements
- R1: Byte offsets 0x0, 0x2 and 0x4 read 0xAAAA, 0x5555 and 0xCAFE respectively, and writes to these offsets change nothing.
- R2: Offset 0x6 reads the code-revision parameter, which defaults to 0x0107. Writes to this offset are ignored.
- R3: A rising edge on source n, seen after two synchronizer flops, sets bit n of the status register at offset 0x8. The bit stays 1 after the source falls. A source held high does not set the bit again.
- R4: The mask register at offset 0xA is read/write and resets to 0x0000. A 1 in bit n keeps source n from raising the request.
- R5: `irq_n` is 0 exactly when some bit has status 1 and mask 0, one clock after that condition holds, and 1 otherwise.
- R6: The clear register at offset 0xC is read/write. While its bit n is 1, status bit n reads 0 and a new edge on source n is lost.
- R7: Writing 0xFFFF and then 0x0000 to offset 0xC leaves every status bit at 0, and new edges are captured again afterwards.
- R8: After reset, status, mask and clear all read 0x0000, `irq_n` is 1 and `rd_data` is 0.
- R9: Reads of odd offsets and of offset 0xE return 0x0000.
- R10: Status bits latch while masked. Clearing the mask bit of an already-set status bit drives `irq_n` low on the second clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Asynchronous interrupt source levels |
| addr | input | ADDR_W | Byte offset of the accessed register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read data, valid one clock after `rd_en` |
| irq_n | output | 1 | Active-low level interrupt request |

## Verification
The bench fires edges on sources whose mask bit is set, then unmasks them. A design that drops masked edges, or that gates the status bits instead of the request, would keep the line high at that point. It also pulses sources while their clear bit is held. A design that treats the clear as a single-cycle pulse would show those bits set again, and one that lets a set win over the clear would flag them at once. It writes to the signature, version and unmapped offsets and reads them back, to catch decode aliasing that turns a read-only word into a writable one or returns stale data. Random mixes of pulses, mask writes and clear writes check the line level against a model after every step.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int OFS_SIG0   = 'h0;
    localparam int OFS_SIG1   = 'h2;
    localparam int OFS_SIG2   = 'h4;
    localparam int OFS_REV    = 'h6;
    localparam int OFS_STATUS = 'h8;
    localparam int OFS_MASK   = 'hA;
    localparam int OFS_CLEAR  = 'hC;

    localparam logic [15:0] SIG0_WORD = 16'hAAAA;
    localparam logic [15:0] SIG1_WORD = 16'h5555;
    localparam logic [15:0] SIG2_WORD = 16'hCAFE;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/irqagg_src_capture.sv
module irqagg_src_capture #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] rise_o
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic meta_q, sync_q, last_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= src_i[i];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end
        assign rise_o[i] = sync_q & ~last_q;
    end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs #(
    parameter int N_SRC  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  rise_i,
    input  logic              mask_we,
    input  logic              clear_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_SRC-1:0]  status_o,
    output logic [N_SRC-1:0]  mask_o,
    output logic [N_SRC-1:0]  clear_o
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic st_q, mk_q, cl_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mk_q <= 1'b0;
                cl_q <= 1'b0;
            end else begin
                if (mask_we)  mk_q <= wdata[i];
                if (clear_we) cl_q <= wdata[i];
            end
        end
        // a held clear beats any set request on the same edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       st_q <= 1'b0;
            else if (cl_q)    st_q <= 1'b0;
            else if (rise_i[i]) st_q <= 1'b1;
        end
        assign status_o[i] = st_q;
        assign mask_o[i]   = mk_q;
        assign clear_o[i]  = cl_q;
    end
endmodule

// File: rtl/irqagg_irq_fsm.sv
module irqagg_irq_fsm
    import irqagg_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pending_i,
    output logic             irq_n
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (|pending_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!(|pending_i)) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/irqagg_readmux.sv
module irqagg_readmux
    import irqagg_pkg::*;
#(
    parameter int          N_SRC   = 16,
    parameter int          DATA_W  = 16,
    parameter int          ADDR_W  = 4,
    parameter logic [15:0] REV_WORD = 16'h0107
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  status_i,
    input  logic [N_SRC-1:0]  mask_i,
    input  logic [N_SRC-1:0]  clear_i,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sel;

    function automatic logic [DATA_W-1:0] widen(input logic [N_SRC-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[N_SRC-1:0] = v;
        return r;
    endfunction

    always_comb begin
        sel = '0;
        if (addr == ADDR_W'(OFS_SIG0))        sel = DATA_W'(SIG0_WORD);
        else if (addr == ADDR_W'(OFS_SIG1))   sel = DATA_W'(SIG1_WORD);
        else if (addr == ADDR_W'(OFS_SIG2))   sel = DATA_W'(SIG2_WORD);
        else if (addr == ADDR_W'(OFS_REV))    sel = DATA_W'(REV_WORD);
        else if (addr == ADDR_W'(OFS_STATUS)) sel = widen(status_i);
        else if (addr == ADDR_W'(OFS_MASK))   sel = widen(mask_i);
        else if (addr == ADDR_W'(OFS_CLEAR))  sel = widen(clear_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int          N_SRC    = 16,
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 4,
    parameter logic [15:0] REV_WORD = 16'h0107
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] clr_q;
    logic [N_SRC-1:0] pending;
    logic             mask_we;
    logic             clear_we;

    assign mask_we  = wr_en && (addr == ADDR_W'(OFS_MASK));
    assign clear_we = wr_en && (addr == ADDR_W'(OFS_CLEAR));
    assign pending  = status_q & ~mask_q;

    irqagg_src_capture #(.N_SRC(N_SRC)) cap_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise)
    );

    irqagg_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .rise_i(rise),
        .mask_we(mask_we), .clear_we(clear_we), .wdata(wr_data),
        .status_o(status_q), .mask_o(mask_q), .clear_o(clr_q)
    );

    irqagg_irq_fsm #(.N_SRC(N_SRC)) fsm_i (
        .clk(clk), .rst_n(rst_n), .pending_i(pending), .irq_n(irq_n)
    );

    irqagg_readmux #(
        .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REV_WORD(REV_WORD)
    ) rmux_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .status_i(status_q), .mask_i(mask_q), .clear_i(clr_q),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
    parameter int          N_SRC    = 16,
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 4,
    parameter logic [15:0] REV_WORD = 16'h0107
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_n,
    input logic [N_SRC-1:0]  status_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  clr_q
);
    p_sig0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(0)) |=> rd_data == DATA_W'(16'hAAAA));

    p_sig2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(4)) |=> rd_data == DATA_W'(16'hCAFE));

    p_rev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(6)) |=> rd_data == DATA_W'(REV_WORD));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_q) & ~$past(clr_q) & ~status_q) == '0);

    p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(10)) |=> mask_q == $past(wr_data[N_SRC-1:0]));

    p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(|($past(status_q) & ~$past(mask_q))));

    p_clear_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & $past(clr_q)) == '0);

    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr[0] || addr == ADDR_W'(14))) |=> rd_data == '0);
endmodule

bind irqagg_top irqagg_checker #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REV_WORD(REV_WORD)
) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n),
    .status_q(status_q), .mask_q(mask_q), .clr_q(clr_q)
);

// File: tb/irqagg_top_tb_top.sv
`timescale 1ns/1ps
module irqagg_top_tb_top;
    localparam int N = 16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_status = '0;
    logic [15:0] m_mask = '0;
    logic [15:0] m_clr = '0;

    always #2 clk = ~clk;

    irqagg_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n)
    );

    function automatic logic exp_irq_n(input logic [15:0] st, input logic [15:0] mk);
        return !(|(st & ~mk));
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input logic [15:0] bits);
        @(negedge clk);
        src = bits;
        repeat (4) @(negedge clk);
        src = '0;
        repeat (4) @(negedge clk);
        m_status = m_status | (bits & ~m_clr);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 irq_n", {15'd0, irq_n}, 16'd1);
        chk("R8 rd_data", rd_data, 16'h0000);
        rst_n = 1'b1;
        rd(4'h8, d); chk("R8 status", d, 16'h0000);
        rd(4'hA, d); chk("R8 mask", d, 16'h0000);
        rd(4'hC, d); chk("R8 clear", d, 16'h0000);
        // R1 / R2 signatures, including write attempts
        wr(4'h0, 16'h1234); wr(4'h2, 16'h0000); wr(4'h4, 16'hFFFF); wr(4'h6, 16'h0);
        rd(4'h0, d); chk("R1 sig0", d, 16'hAAAA);
        rd(4'h2, d); chk("R1 sig1", d, 16'h5555);
        rd(4'h4, d); chk("R1 sig2", d, 16'hCAFE);
        rd(4'h6, d); chk("R2 rev", d, 16'h0107);
        // R9 unmapped
        wr(4'hE, 16'hBEEF);
        rd(4'hE, d); chk("R9 ofs E", d, 16'h0000);
        rd(4'h3, d); chk("R9 ofs 3", d, 16'h0000);
        rd(4'h9, d); chk("R9 ofs 9", d, 16'h0000);
        // R3 edge sets sticky bit, held level no re-set
        pulse(16'h0005); settle();
        rd(4'h8, d); chk("R3 sticky", d, m_status);
        chk("R5 irq low", {15'd0, irq_n}, 16'd0);
        @(negedge clk); src = 16'h0001;
        wr(4'hC, 16'h0001); wr(4'hC, 16'h0000); m_status[0] = 1'b0; settle();
        rd(4'h8, d); chk("R3 held level no reset", d, m_status);
        @(negedge clk); src = '0; settle();
        // R4 / R10 masked latch then unmask
        wr(4'hC, 16'hFFFF); wr(4'hC, 16'h0000); m_status = '0; settle();
        chk("R7 all cleared irq", {15'd0, irq_n}, 16'd1);
        rd(4'h8, d); chk("R7 all cleared", d, 16'h0000);
        wr(4'hA, 16'h0080); m_mask = 16'h0080;
        rd(4'hA, d); chk("R4 mask readback", d, 16'h0080);
        pulse(16'h0080); settle();
        chk("R4 masked irq high", {15'd0, irq_n}, 16'd1);
        rd(4'h8, d); chk("R10 latched while masked", d, 16'h0080);
        wr(4'hA, 16'h0000); m_mask = '0;
        chk("R10 not yet", {15'd0, irq_n}, 16'd1);
        @(negedge clk);
        chk("R10 unmask asserts", {15'd0, irq_n}, 16'd0);
        // R6 clear held blocks new edges
        wr(4'hC, 16'h0300); m_clr = 16'h0300; m_status = m_status & ~m_clr;
        pulse(16'h0300); settle();
        rd(4'h8, d); chk("R6 edge lost under clear", d, m_status);
        rd(4'hC, d); chk("R6 clear readback", d, 16'h0300);
        wr(4'hC, 16'h0000); m_clr = '0;
        pulse(16'h0200); settle();
        rd(4'h8, d); chk("R7 capture after release", d, m_status);
        // random mix
        for (int k = 0; k < 200; k++) begin
            int op = $urandom_range(0, 3);
            logic [15:0] v = 16'($urandom);
            if (op == 0) pulse(v & ~src);
            else if (op == 1) begin wr(4'hA, v); m_mask = v; end
            else if (op == 2) begin wr(4'hC, v); m_clr = v; m_status = m_status & ~v; end
            else begin wr(4'hC, 16'h0000); m_clr = '0; end
            settle();
            chk("R5 random irq", {15'd0, irq_n}, {15'd0, exp_irq_n(m_status, m_mask)});
            rd(4'h8, d); chk("R3 random status", d, m_status);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule